// File: doc/BRIEF.md
# Accumulator Word Processor Core

A multicycle core for a small accumulator machine with 24-bit two's complement words and a 15-bit byte address space. Each instruction is three bytes long: an 8-bit opcode, an index flag, and a 15-bit address field. The core holds an accumulator, an index register, a link register, a program counter and a two-bit condition code. It runs loads and stores of any of the three registers, add, subtract, signed compare, an index-step-and-compare loop instruction, conditional and unconditional jumps, subroutine call and return, and single-byte load and store.

The core reaches memory through one byte-wide synchronous port. A read issued in one cycle returns its byte on `mem_rdata` in the next cycle. Reads are pipelined, so a 3-byte word is read in four cycles and written in three. Words are big-endian: the lowest address holds the most significant byte. Any opcode outside the implemented set stops the core for good and raises a flag. Multiply, divide and device I/O opcodes are handled this way.

Top module: `acc24_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the core reads address 0. No write is issued and `halted` and `illegal` are low.
- R2: An instruction is read byte by byte from PC, PC+1 and PC+2 in consecutive cycles. Byte 0 is the opcode. Bit 7 of byte 1 is the index flag. The remaining 15 bits, high bits first, are the address field. Execution continues at PC+3 unless a jump is taken.
- R3: The target address is the address field when the index flag is 0. When the flag is 1 it is the address field plus the low 15 bits of X, modulo 2^15.
- R4: Word loads (opcodes 00 A, 04 X, 08 L) and word stores (0C A, 10 X, 14 L) move three bytes at TA, TA+1 and TA+2, most significant byte first. A store writes on consecutive addresses.
- R5: ADD (18) and SUB (1C) set A to A plus or minus the memory word, modulo 2^24.
- R6: COMP (28) compares A with the memory word as signed numbers and sets CC to 00 (less), 01 (equal) or 10 (greater). JLT (38), JEQ (30) and JGT (34) load PC with TA only when CC matches. J (3C) always jumps.
- R7: JSUB (48) writes the address of the next instruction into L and jumps to TA. RSUB (4C) jumps to the low 15 bits of L.
- R8: TIX (2C) adds 1 to X, compares the new X with the word at TA as signed numbers, and sets CC the same way as COMP.
- R9: LDCH (50) replaces only A[7:0] with the byte at TA. STCH (54) writes only A[7:0] to the single byte at TA.
- R10: Any other opcode raises `illegal` and `halted`. From then on no memory access is issued, and both flags stay high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 15 | Byte address of the current access |
| mem_rd_en | output | 1 | Read request; data is returned one cycle later |
| mem_wr_en | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned for the previous cycle's read |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an unimplemented opcode |

## Verification
The arithmetic sweep pairs operands at the signed extremes: 0x7FFFFF against 0x800000, minus one against one, and equal values. A compare done unsigned would send JLT and JGT the wrong way, and a carry kept past bit 23 would corrupt the stored sum. The byte-copy loop is run for several lengths. It checks the exit count of the increment-and-compare instruction, that a byte load keeps A[23:8], and that a byte store leaves the next byte alone. Each of these catches a loop that runs off by one, a load that clears the upper bits, or a store that writes a whole word. An indexed access whose sum passes 2^15 must wrap to low memory, and the return address saved by a call must point past the call. An illegal opcode must leave the memory port quiet from then on.

// File: rtl/acc24_pkg.sv
package acc24_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_B  = 3;
    localparam int WORD_W  = BYTE_W * WORD_B;
    localparam int ADDR_W  = 15;
    localparam int CNT_W   = 2;

    localparam logic [1:0] CC_LT = 2'b00;
    localparam logic [1:0] CC_EQ = 2'b01;
    localparam logic [1:0] CC_GT = 2'b10;

    typedef enum logic [2:0] {
        ST_FETCH, ST_EXEC, ST_READ, ST_WRITE, ST_HALT
    } st_e;

    typedef enum logic [4:0] {
        OP_LDA, OP_LDX, OP_LDL, OP_STA, OP_STX, OP_STL,
        OP_ADD, OP_SUB, OP_COMP, OP_TIX,
        OP_JEQ, OP_JGT, OP_JLT, OP_J, OP_JSUB, OP_RSUB,
        OP_LDCH, OP_STCH, OP_ILL
    } op_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        op_e               op;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] opnd;
        logic [ADDR_W-1:0] ta;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] l;
        logic [1:0]        cc;
        logic              ill;
    } core_t;
endpackage

// File: rtl/acc24_decode.sv
module acc24_decode
    import acc24_pkg::*;
(
    input  logic [BYTE_W-1:0] opc,
    output op_e               op
);
    always_comb begin
        case (opc)
            8'h00: op = OP_LDA;
            8'h04: op = OP_LDX;
            8'h08: op = OP_LDL;
            8'h0C: op = OP_STA;
            8'h10: op = OP_STX;
            8'h14: op = OP_STL;
            8'h18: op = OP_ADD;
            8'h1C: op = OP_SUB;
            8'h28: op = OP_COMP;
            8'h2C: op = OP_TIX;
            8'h30: op = OP_JEQ;
            8'h34: op = OP_JGT;
            8'h38: op = OP_JLT;
            8'h3C: op = OP_J;
            8'h48: op = OP_JSUB;
            8'h4C: op = OP_RSUB;
            8'h50: op = OP_LDCH;
            8'h54: op = OP_STCH;
            default: op = OP_ILL;
        endcase
    end
endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
    import acc24_pkg::*;
(
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              sub,
    output logic [WORD_W-1:0] res,
    output logic [1:0]        cc
);
    always_comb begin
        res = sub ? (opa - opb) : (opa + opb);
        if ($signed(opa) < $signed(opb))      cc = CC_LT;
        else if (opa == opb)                  cc = CC_EQ;
        else                                  cc = CC_GT;
    end
endmodule

// File: rtl/acc24_core.sv
module acc24_core
    import acc24_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              halted,
    output logic              illegal
);
    localparam logic [CNT_W-1:0]  LEN_WORD = CNT_W'(WORD_B);
    localparam logic [CNT_W-1:0]  LEN_BYTE = CNT_W'(1);
    localparam logic [ADDR_W-1:0] INS_LEN  = ADDR_W'(WORD_B);

    core_t r_q, r_d;
    op_e               dec_op;
    logic [WORD_W-1:0] full_w, alu_a, alu_res;
    logic [1:0]        alu_cc;
    logic [ADDR_W-1:0] ta_calc;
    st_e               fsm_st;
    logic [CNT_W-1:0]  fsm_cnt;

    assign fsm_st  = r_q.st;
    assign fsm_cnt = r_q.cnt;

    acc24_decode u_dec (.opc(r_q.ir[WORD_W-1 -: BYTE_W]), .op(dec_op));

    assign full_w  = {r_q.opnd[WORD_W-BYTE_W-1:0], mem_rdata};
    assign alu_a   = (r_q.op == OP_TIX) ? (r_q.x + WORD_W'(1)) : r_q.a;
    assign ta_calc = r_q.ir[ADDR_W-1:0] + (r_q.ir[ADDR_W] ? r_q.x[ADDR_W-1:0] : '0);

    acc24_alu u_alu (
        .opa(alu_a), .opb(full_w), .sub(r_q.op != OP_ADD),
        .res(alu_res), .cc(alu_cc)
    );

    always_comb begin
        r_d       = r_q;
        mem_addr  = '0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_wdata = '0;
        case (r_q.st)
            ST_FETCH: begin
                mem_addr  = r_q.pc + ADDR_W'(r_q.cnt);
                mem_rd_en = (r_q.cnt != LEN_WORD);
                if (r_q.cnt != '0) r_d.ir = full_w_ir(r_q.ir, mem_rdata);
                if (r_q.cnt == LEN_WORD) begin
                    r_d.pc  = r_q.pc + INS_LEN;
                    r_d.st  = ST_EXEC;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_EXEC: begin
                r_d.op  = dec_op;
                r_d.ta  = ta_calc;
                r_d.cnt = '0;
                r_d.len = LEN_WORD;
                r_d.st  = ST_READ;
                case (dec_op)
                    OP_ILL:  begin r_d.st = ST_HALT; r_d.ill = 1'b1; end
                    OP_J:    begin r_d.pc = ta_calc; r_d.st = ST_FETCH; end
                    OP_JEQ:  begin if (r_q.cc == CC_EQ) r_d.pc = ta_calc; r_d.st = ST_FETCH; end
                    OP_JGT:  begin if (r_q.cc == CC_GT) r_d.pc = ta_calc; r_d.st = ST_FETCH; end
                    OP_JLT:  begin if (r_q.cc == CC_LT) r_d.pc = ta_calc; r_d.st = ST_FETCH; end
                    OP_JSUB: begin
                        r_d.l  = WORD_W'(r_q.pc);
                        r_d.pc = ta_calc;
                        r_d.st = ST_FETCH;
                    end
                    OP_RSUB: begin r_d.pc = r_q.l[ADDR_W-1:0]; r_d.st = ST_FETCH; end
                    OP_STA:  begin r_d.opnd = r_q.a; r_d.st = ST_WRITE; end
                    OP_STX:  begin r_d.opnd = r_q.x; r_d.st = ST_WRITE; end
                    OP_STL:  begin r_d.opnd = r_q.l; r_d.st = ST_WRITE; end
                    OP_STCH: begin
                        r_d.opnd = {r_q.a[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
                        r_d.len  = LEN_BYTE;
                        r_d.st   = ST_WRITE;
                    end
                    OP_LDCH: r_d.len = LEN_BYTE;
                    default: ;
                endcase
            end
            ST_READ: begin
                mem_addr  = r_q.ta + ADDR_W'(r_q.cnt);
                mem_rd_en = (r_q.cnt != r_q.len);
                if (r_q.cnt != '0) r_d.opnd = full_w;
                if (r_q.cnt == r_q.len) begin
                    r_d.st  = ST_FETCH;
                    r_d.cnt = '0;
                    case (r_q.op)
                        OP_LDA:  r_d.a = full_w;
                        OP_LDX:  r_d.x = full_w;
                        OP_LDL:  r_d.l = full_w;
                        OP_ADD,
                        OP_SUB:  r_d.a = alu_res;
                        OP_COMP: r_d.cc = alu_cc;
                        OP_TIX:  begin r_d.x = alu_a; r_d.cc = alu_cc; end
                        OP_LDCH: r_d.a = {r_q.a[WORD_W-1:BYTE_W], mem_rdata};
                        default: ;
                    endcase
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WRITE: begin
                mem_addr  = r_q.ta + ADDR_W'(r_q.cnt);
                mem_wr_en = 1'b1;
                mem_wdata = r_q.opnd[WORD_W-1 -: BYTE_W];
                r_d.opnd  = r_q.opnd << BYTE_W;
                if (r_q.cnt == r_q.len - 1'b1) begin
                    r_d.st  = ST_FETCH;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
    end

    function automatic logic [WORD_W-1:0] full_w_ir(input logic [WORD_W-1:0] cur,
                                                    input logic [BYTE_W-1:0] b);
        return {cur[WORD_W-BYTE_W-1:0], b};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_FETCH, op: OP_LDA, cc: CC_LT, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign halted  = (r_q.st == ST_HALT);
    assign illegal = r_q.ill;
endmodule

// File: rtl/acc24_chk.sv
module acc24_chk
    import acc24_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              halted,
    input logic              illegal,
    input st_e               st,
    input logic [CNT_W-1:0]  cnt
);
    assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH && cnt != 2'd0 && cnt != 2'd3) |-> (mem_addr == $past(mem_addr) + 15'd1));

    assert_store_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && cnt != 2'd0) |-> (mem_addr == $past(mem_addr) + 15'd1));

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd_en && !mem_wr_en));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(illegal)));

    assert_illegal_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);
endmodule

bind acc24_core acc24_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .halted(halted), .illegal(illegal),
    .st(fsm_st), .cnt(fsm_cnt)
);

// File: tb/tb_acc24_core.sv
module tb_acc24_core;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        halted, illegal;
    logic [7:0]  mem [0:MEM_N-1];
    int          n_vec = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc24_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .illegal(illegal)
    );

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    endtask

    task automatic put_ins(input int at, input logic [7:0] op, input logic x, input logic [14:0] ta);
        mem[at] = op; mem[at+1] = {x, ta[14:8]}; mem[at+2] = ta[7:0];
    endtask

    task automatic put_word(input int at, input logic [23:0] w);
        mem[at] = w[23:16]; mem[at+1] = w[15:8]; mem[at+2] = w[7:0];
    endtask

    function automatic logic [23:0] get_word(input int at);
        return {mem[at], mem[at+1], mem[at+2]};
    endfunction

    task automatic start();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt(input string req);
        int k = 0;
        while (!halted && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(req, {23'd0, halted}, 24'd1);
    endtask

    logic [23:0] vals [8];

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        vals = '{24'h000000, 24'h000001, 24'hFFFFFF, 24'h7FFFFF,
                 24'h800000, 24'h123456, 24'hFEDCBA, 24'h000002};

        // R1 R2 R10: reset state, fetch order, illegal opcode trap
        clear_mem();
        mem[0] = 8'hD8;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 rd_en in reset", {23'd0, mem_rd_en}, 24'd1);
        check("R1 addr in reset", {9'd0, mem_addr}, 24'd0);
        rst_n = 1'b1;
        check("R1 no write", {23'd0, mem_wr_en}, 24'd0);
        check("R1 flags low", {22'd0, halted, illegal}, 24'd0);
        for (int k = 1; k < 3; k++) begin
            @(negedge clk);
            check("R2 fetch byte order", {9'd0, mem_addr}, 24'(k));
        end
        run_to_halt("R10 halts");
        check("R10 illegal flag", {23'd0, illegal}, 24'd1);
        begin
            logic any_acc = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (mem_rd_en || mem_wr_en || !halted || !illegal) any_acc = 1'b1;
            end
            check("R10 quiet after halt", {23'd0, any_acc}, 24'd0);
        end

        // R4 R5 R6: arithmetic and compare sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [23:0] e_cmp;
                clear_mem();
                put_ins(0,  8'h00, 0, 15'h200);
                put_ins(3,  8'h18, 0, 15'h203);
                put_ins(6,  8'h0C, 0, 15'h210);
                put_ins(9,  8'h00, 0, 15'h200);
                put_ins(12, 8'h1C, 0, 15'h203);
                put_ins(15, 8'h0C, 0, 15'h213);
                put_ins(18, 8'h00, 0, 15'h200);
                put_ins(21, 8'h28, 0, 15'h203);
                put_ins(24, 8'h38, 0, 15'd36);
                put_ins(27, 8'h30, 0, 15'd42);
                put_ins(30, 8'h34, 0, 15'd48);
                mem[33] = 8'hFF;
                put_ins(36, 8'h00, 0, 15'h206);
                put_ins(39, 8'h3C, 0, 15'd54);
                put_ins(42, 8'h00, 0, 15'h209);
                put_ins(45, 8'h3C, 0, 15'd54);
                put_ins(48, 8'h00, 0, 15'h20C);
                put_ins(51, 8'h3C, 0, 15'd54);
                put_ins(54, 8'h0C, 0, 15'h216);
                mem[57] = 8'hFF;
                put_word(15'h200, vals[i]);
                put_word(15'h203, vals[j]);
                put_word(15'h206, 24'd1);
                put_word(15'h209, 24'd2);
                put_word(15'h20C, 24'd3);
                start();
                run_to_halt("R6 program end");
                if ($signed(vals[i]) < $signed(vals[j])) e_cmp = 24'd1;
                else if (vals[i] == vals[j])             e_cmp = 24'd2;
                else                                     e_cmp = 24'd3;
                check("R5 add", get_word(15'h210), vals[i] + vals[j]);
                check("R5 sub", get_word(15'h213), vals[i] - vals[j]);
                check("R6 compare branch", get_word(15'h216), e_cmp);
                check("R4 store order", {16'd0, mem[15'h210]}, {16'd0, 8'((vals[i] + vals[j]) >> 16)});
            end
        end

        // R7 R8 R9 R3 R4: byte copy loop with TIX, call and return
        for (int n = 1; n <= 6; n++) begin
            clear_mem();
            put_ins(0,  8'h00, 0, 15'h30C);
            put_ins(3,  8'h04, 0, 15'h300);
            put_ins(6,  8'h50, 1, 15'h400);
            put_ins(9,  8'h54, 1, 15'h500);
            put_ins(12, 8'h2C, 0, 15'h303);
            put_ins(15, 8'h38, 0, 15'd6);
            put_ins(18, 8'h10, 0, 15'h306);
            put_ins(21, 8'h0C, 0, 15'h312);
            put_ins(24, 8'h48, 0, 15'd36);
            put_ins(27, 8'h14, 0, 15'h309);
            mem[30] = 8'hFF;
            put_ins(36, 8'h00, 0, 15'h315);
            put_ins(39, 8'h0C, 0, 15'h30F);
            put_ins(42, 8'h4C, 0, 15'h000);
            put_word(15'h300, 24'd0);
            put_word(15'h303, 24'(n));
            put_word(15'h30C, 24'hABCDEF);
            put_word(15'h315, 24'h5A0F3C);
            for (int b = 0; b < 8; b++) begin
                mem[15'h400 + b] = 8'((b * 37 + 5) & 8'hFF);
                mem[15'h500 + b] = 8'h5A;
            end
            start();
            run_to_halt("R7 return reaches end");
            check("R8 loop exit X", get_word(15'h306), 24'(n));
            check("R9 LDCH keeps upper A", get_word(15'h312), {16'hABCD, 8'(((n - 1) * 37 + 5) & 8'hFF)});
            check("R7 link value", get_word(15'h309), 24'd27);
            check("R7 subroutine ran", get_word(15'h30F), 24'h5A0F3C);
            for (int b = 0; b < n; b++)
                check("R3 indexed byte copy", {16'd0, mem[15'h500 + b]}, {16'd0, 8'((b * 37 + 5) & 8'hFF)});
            check("R9 STCH single byte", {16'd0, mem[15'h500 + n]}, 24'h00005A);
            check("R4 illegal flag at end", {23'd0, illegal}, 24'd1);
        end

        // R3: indexed address wraps modulo 2^15
        clear_mem();
        put_ins(0, 8'h04, 0, 15'h300);
        put_ins(3, 8'h00, 1, 15'h7F10);
        put_ins(6, 8'h0C, 0, 15'h320);
        mem[9] = 8'hFF;
        put_word(15'h300, 24'h000200);
        put_word(15'h110, 24'h112233);
        start();
        run_to_halt("R3 wrap program end");
        check("R3 address wrap", get_word(15'h320), 24'h112233);

        // R8: TIX with negative X sets CC equal at zero crossing
        clear_mem();
        put_ins(0,  8'h04, 0, 15'h300);
        put_ins(3,  8'h2C, 0, 15'h303);
        put_ins(6,  8'h30, 0, 15'd15);
        put_ins(9,  8'h00, 0, 15'h306);
        put_ins(12, 8'h3C, 0, 15'd18);
        put_ins(15, 8'h00, 0, 15'h309);
        put_ins(18, 8'h0C, 0, 15'h30C);
        mem[21] = 8'hFF;
        put_word(15'h300, 24'hFFFFFF);
        put_word(15'h303, 24'h000000);
        put_word(15'h306, 24'd7);
        put_word(15'h309, 24'd9);
        start();
        run_to_halt("R8 tix program end");
        check("R8 TIX equal from -1", get_word(15'h30C), 24'd9);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule